// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Sequencer

This block fetches instructions for a small 8-bit accumulator machine from a byte-wide memory. It does not execute them. When the execute side asks for work, the sequencer reads an opcode byte at the program counter. A leading page byte sends it back for a second opcode byte and marks the instruction as using the alternate index register. It then classifies the final opcode into one of four addressing modes. Depending on the mode, it reads zero, one or two further bytes from the locations that follow.

The operand bytes are merged into a single 16-bit field. In immediate mode that field is the data value. In zero-page mode it is an address whose upper byte is forced to zero. In full-address mode it is an address whose high byte is read first. The program counter steps once for every byte consumed, so it already points at the next instruction when the record is handed over. The record is held on the outputs with a valid flag until the execute side accepts it. Memory reads have a latency of one cycle: data for a read issued at one clock edge is present on the read-data input during the following cycle.

Top module: `ifetch_seq`

## Requirements
- R1: While `rst` is high, the sequencer returns to idle and drops `out_valid`. The program counter `pc_now` is loaded from `reset_vec` one clock later.
- R2: An opcode whose upper nibble is 0x0 to 0x3 (other than the page byte) is inherent (mode 0). It takes one read, its operand field is 0x0000, and the program counter advances by one.
- R3: If the first byte of an instruction is 0x18, a second opcode byte is read. The record then carries the second byte as its opcode and has `out_prefix_y` set. Otherwise `out_prefix_y` is clear.
- R4: An opcode with upper nibble 0x8 or 0xC is immediate (mode 1). The following byte is delivered as the operand field with an upper byte of 0x00.
- R5: An opcode with upper nibble 0x9 or 0xD is zero-page (mode 2). The following byte becomes the low address byte, and the upper address byte is always 0x00.
- R6: An opcode with upper nibble 0xB or 0xF is full-address (mode 3). Two bytes follow: the first is the high address byte and the second is the low address byte.
- R7: The program counter increments exactly once per memory read and holds otherwise. When a record is valid, `pc_now` equals `out_start_pc` plus the instruction's byte count.
- R8: Any other opcode sets `out_illegal`, is reported as mode 0, and consumes no operand bytes.
- R9: A 0x18 byte that follows a 0x18 byte ends the instruction. The record is illegal, mode 0, with opcode 0x18 and `out_prefix_y` set, and the byte after it starts a new instruction.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` and every record field hold their values.
- R11: The number of reads per instruction is 1, plus 1 for a page byte, plus 0, 1 or 2 operand bytes. No read is issued while `out_valid` is high.
- R12: In idle with `start` low, no read is issued and the program counter holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_vec | input | AW | Program counter value loaded at reset |
| start | input | 1 | Request to begin fetching the next instruction |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory read address |
| mem_rdata | input | DW | Read data, valid one cycle after the strobe |
| out_valid | output | 1 | Decoded record is present |
| out_ready | input | 1 | Execute side accepts the record |
| out_opcode | output | DW | Final opcode byte |
| out_prefix_y | output | 1 | Instruction uses the alternate index register |
| out_mode | output | 2 | 0 inherent, 1 immediate, 2 zero-page, 3 full-address |
| out_operand | output | AW | Immediate value or effective address |
| out_illegal | output | 1 | Opcode not in the decode table |
| out_start_pc | output | AW | Address of the instruction's first byte |
| pc_now | output | AW | Current program counter |

## Verification
The hardest case to reach from the ports is a run of back-to-back page bytes. In that case the sequencer must stop after the second one, and the third byte must be decoded as the start of a fresh instruction. The program image places 0x18 0x18 directly in front of an immediate instruction, and the scoreboard expects two separate records with the right start addresses. The idle hold is reached by dropping `start` for a window. The bench then waits for an acceptance inside that window, after which every further read strobe counts as an error. Meanwhile a cyclic ready pattern keeps records waiting, which exercises the hold behaviour.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;

  typedef enum logic [1:0] {
    MODE_INH = 2'd0,
    MODE_IMM = 2'd1,
    MODE_DIR = 2'd2,
    MODE_EXT = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPCODE,
    ST_PFX_OPCODE,
    ST_OPND_HI,
    ST_OPND_LO,
    ST_DONE
  } fetch_state_e;

endpackage

// File: rtl/ifetch_decode.sv
module ifetch_decode
  import ifetch_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] opcode,
  output mode_e         mode,
  output logic          illegal
);

  localparam int NIB = 4;

  logic [NIB-1:0] grp;
  assign grp = opcode[DW-1 -: NIB];

  always_comb begin
    mode    = MODE_INH;
    illegal = 1'b0;
    case (grp)
      4'h0, 4'h1, 4'h2, 4'h3: mode = MODE_INH;
      4'h8, 4'hC:             mode = MODE_IMM;
      4'h9, 4'hD:             mode = MODE_DIR;
      4'hB, 4'hF:             mode = MODE_EXT;
      default: begin
        mode    = MODE_INH;
        illegal = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/ifetch_pc.sv
module ifetch_pc #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic [AW-1:0] pc
);

  always_ff @(posedge clk) begin
    if (rst)       pc <= load_val;
    else if (step) pc <= pc + AW'(1);
  end

endmodule

// File: rtl/ifetch_seq.sv
module ifetch_seq
  import ifetch_pkg::*;
#(
  parameter int          DW       = 8,
  parameter int          AW       = 2 * DW,
  parameter logic [7:0]  PFX_CODE = 8'h18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] reset_vec,
  input  logic          start,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_opcode,
  output logic          out_prefix_y,
  output logic [1:0]    out_mode,
  output logic [AW-1:0] out_operand,
  output logic          out_illegal,
  output logic [AW-1:0] out_start_pc,
  output logic [AW-1:0] pc_now
);

  localparam logic [DW-1:0] PFX = DW'(PFX_CODE);

  fetch_state_e  state;
  mode_e         dec_mode;
  logic          dec_illegal;
  logic          is_pfx;
  logic          take_opc;
  logic          dbl_pfx;
  logic [DW-1:0] hi_q;
  mode_e         mode_q;

  ifetch_decode #(.DW(DW)) u_dec (
    .opcode  (mem_rdata),
    .mode    (dec_mode),
    .illegal (dec_illegal)
  );

  ifetch_pc #(.AW(AW)) u_pc (
    .clk      (clk),
    .rst      (rst),
    .load_val (reset_vec),
    .step     (mem_rd_en),
    .pc       (pc_now)
  );

  assign is_pfx   = (mem_rdata == PFX);
  assign take_opc = ((state == ST_OPCODE) || (state == ST_PFX_OPCODE)) && !is_pfx;
  assign dbl_pfx  = (state == ST_PFX_OPCODE) && is_pfx;

  always_comb begin
    mem_rd_en = 1'b0;
    case (state)
      ST_IDLE:       mem_rd_en = start;
      ST_OPCODE:     mem_rd_en = is_pfx || (dec_mode != MODE_INH);
      ST_PFX_OPCODE: mem_rd_en = !is_pfx && (dec_mode != MODE_INH);
      ST_OPND_HI:    mem_rd_en = 1'b1;
      default:       mem_rd_en = 1'b0;
    endcase
  end

  assign mem_addr = pc_now;
  assign out_mode = mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      out_valid    <= 1'b0;
      out_opcode   <= '0;
      out_prefix_y <= 1'b0;
      mode_q       <= MODE_INH;
      out_operand  <= '0;
      out_illegal  <= 1'b0;
      out_start_pc <= '0;
      hi_q         <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            out_start_pc <= pc_now;
            out_prefix_y <= 1'b0;
            out_illegal  <= 1'b0;
            out_operand  <= '0;
            hi_q         <= '0;
            state        <= ST_OPCODE;
          end
        end
        ST_OPCODE, ST_PFX_OPCODE: begin
          if (take_opc) begin
            out_opcode  <= mem_rdata;
            mode_q      <= dec_mode;
            out_illegal <= dec_illegal;
            case (dec_mode)
              MODE_INH: begin
                out_valid <= 1'b1;
                state     <= ST_DONE;
              end
              MODE_EXT: state <= ST_OPND_HI;
              default:  state <= ST_OPND_LO;
            endcase
          end else if (dbl_pfx) begin
            out_opcode  <= mem_rdata;
            mode_q      <= MODE_INH;
            out_illegal <= 1'b1;
            out_valid   <= 1'b1;
            state       <= ST_DONE;
          end else begin
            out_prefix_y <= 1'b1;
            state        <= ST_PFX_OPCODE;
          end
        end
        ST_OPND_HI: begin
          hi_q  <= mem_rdata;
          state <= ST_OPND_LO;
        end
        ST_OPND_LO: begin
          out_operand <= {hi_q, mem_rdata};
          out_valid   <= 1'b1;
          state       <= ST_DONE;
        end
        ST_DONE: begin
          if (out_ready) begin
            out_valid <= 1'b0;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ifetch_seq_chk.sv
module ifetch_seq_chk #(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] reset_vec,
  input logic          mem_rd_en,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_opcode,
  input logic          out_prefix_y,
  input logic [1:0]    out_mode,
  input logic [AW-1:0] out_operand,
  input logic          out_illegal,
  input logic [AW-1:0] out_start_pc,
  input logic [AW-1:0] pc_now
);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && pc_now == $past(reset_vec)));

  p_pc_step_r7: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> (pc_now == AW'($past(pc_now) + AW'(1))));

  p_pc_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !mem_rd_en |=> $stable(pc_now));

  p_no_read_valid_r11: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !mem_rd_en);

  p_hold_record_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_opcode)
      && $stable(out_prefix_y) && $stable(out_mode) && $stable(out_operand)
      && $stable(out_illegal) && $stable(out_start_pc)));

  p_imm_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_mode == 2'd1) |-> (out_operand[AW-1:DW] == '0));

  p_zero_page_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_mode == 2'd2) |-> (out_operand[AW-1:DW] == '0));

  p_illegal_inherent_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal) |-> (out_mode == 2'd0));

endmodule

bind ifetch_seq ifetch_seq_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .reset_vec    (reset_vec),
  .mem_rd_en    (mem_rd_en),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_opcode   (out_opcode),
  .out_prefix_y (out_prefix_y),
  .out_mode     (out_mode),
  .out_operand  (out_operand),
  .out_illegal  (out_illegal),
  .out_start_pc (out_start_pc),
  .pc_now       (pc_now)
);

// File: tb/ifetch_seq_bench.sv
module ifetch_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int AW = 16;
  localparam logic [AW-1:0] RVEC = 16'h0100;
  localparam int WIN_LO = 30;
  localparam int WIN_HI = 60;

  typedef struct {
    logic [7:0]  opc;
    logic        pfx;
    logic [1:0]  mode;
    logic [15:0] opnd;
    logic        ill;
    logic [15:0] spc;
    int          len;
    string       tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst;
  logic          start;
  logic          mem_rd_en;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata;
  logic          out_valid;
  logic          out_ready;
  logic [DW-1:0] out_opcode;
  logic          out_prefix_y;
  logic [1:0]    out_mode;
  logic [AW-1:0] out_operand;
  logic          out_illegal;
  logic [AW-1:0] out_start_pc;
  logic [AW-1:0] pc_now;

  logic [7:0] mem [0:1023];
  exp_t       q[$];
  int         n_chk = 0;
  int         n_fail = 0;
  logic [15:0] wp;
  logic       running = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ifetch_seq #(.DW(DW), .AW(AW)) u_ifetch_seq (
    .clk(clk), .rst(rst), .reset_vec(RVEC), .start(start),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_opcode(out_opcode),
    .out_prefix_y(out_prefix_y), .out_mode(out_mode), .out_operand(out_operand),
    .out_illegal(out_illegal), .out_start_pc(out_start_pc), .pc_now(pc_now)
  );

  always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr[9:0]];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic put(input int n, input logic [7:0] b0, input logic [7:0] b1,
                     input logic [7:0] b2, input logic [7:0] b3,
                     input logic [7:0] opc, input logic pfx, input logic [1:0] mode,
                     input logic [15:0] opnd, input logic ill, input string tag);
    exp_t e;
    logic [7:0] bs [4];
    bs[0] = b0; bs[1] = b1; bs[2] = b2; bs[3] = b3;
    for (int i = 0; i < n; i++) mem[10'(wp + 16'(i))] = bs[i];
    e.opc = opc; e.pfx = pfx; e.mode = mode; e.opnd = opnd; e.ill = ill;
    e.spc = wp; e.len = n; e.tag = tag;
    q.push_back(e);
    wp = wp + 16'(n);
  endtask

  // Monitor / scoreboard
  int          cyc = 0;
  int          reads = 0;
  bit          hold = 0;
  bit          idle_seen = 0;
  int          idle_reads = 0;
  logic [15:0] idle_pc;
  logic [47:0] saved;

  always @(negedge clk) begin
    if (running) begin
      cyc++;
      start     = !(cyc >= WIN_LO && cyc < WIN_HI);
      out_ready = (cyc % 3) != 0;
      #1;
      if (mem_rd_en) begin
        reads++;
        if (idle_seen && !start) idle_reads++;
      end
      if (out_valid) begin
        if (hold)
          check({out_opcode, out_prefix_y, out_mode, out_operand, out_illegal, out_start_pc,
                 3'b0} == saved, "R10", "record held",
                32'(out_operand), 32'(saved[31:16]));
        saved = {out_opcode, out_prefix_y, out_mode, out_operand, out_illegal, out_start_pc, 3'b0};
        if (out_ready && q.size() != 0) begin
          exp_t e;
          e = q.pop_front();
          check(out_opcode == e.opc && out_prefix_y == e.pfx && out_mode == e.mode &&
                out_operand == e.opnd && out_illegal == e.ill && out_start_pc == e.spc,
                e.tag, "record {opc,pfx,mode,ill,operand}",
                {out_opcode, 3'(out_prefix_y), out_mode, 3'(out_illegal), out_operand[7:0]},
                {e.opc, 3'(e.pfx), e.mode, 3'(e.ill), e.opnd[7:0]});
          check(out_operand == e.opnd, e.tag, "operand", 32'(out_operand), 32'(e.opnd));
          check(pc_now == e.spc + 16'(e.len), "R7", "pc after fetch",
                32'(pc_now), 32'(e.spc + 16'(e.len)));
          check(reads == e.len, "R11", "read count", 32'(reads), 32'(e.len));
          reads = 0;
          if (!start && !idle_seen) begin
            idle_seen = 1;
            idle_pc   = pc_now;
          end
        end else if (out_ready) begin
          reads = 0;
        end
        hold = !out_ready;
      end else begin
        hold = 0;
      end
      if (cyc == WIN_HI - 1) begin
        check(idle_seen, "R12", "acceptance inside stall window", 32'(idle_seen), 32'd1);
        check(idle_reads == 0, "R12", "reads while idle", 32'(idle_reads), 32'd0);
        check(pc_now == idle_pc, "R12", "pc while idle", 32'(pc_now), 32'(idle_pc));
      end
    end
  end

  initial begin
    int wd;
    for (int i = 0; i < 1024; i++) mem[i] = 8'h01;
    rst = 1'b1; start = 1'b0; out_ready = 1'b0;
    wp = RVEC;
    put(1, 8'h01, 8'h00, 8'h00, 8'h00, 8'h01, 1'b0, 2'd0, 16'h0000, 1'b0, "R2");
    put(2, 8'h86, 8'h42, 8'h00, 8'h00, 8'h86, 1'b0, 2'd1, 16'h0042, 1'b0, "R4");
    put(2, 8'h96, 8'h7A, 8'h00, 8'h00, 8'h96, 1'b0, 2'd2, 16'h007A, 1'b0, "R5");
    put(3, 8'hB6, 8'h12, 8'h34, 8'h00, 8'hB6, 1'b0, 2'd3, 16'h1234, 1'b0, "R6");
    put(1, 8'h3F, 8'h00, 8'h00, 8'h00, 8'h3F, 1'b0, 2'd0, 16'h0000, 1'b0, "R2");
    put(2, 8'hC5, 8'hFF, 8'h00, 8'h00, 8'hC5, 1'b0, 2'd1, 16'h00FF, 1'b0, "R4");
    put(2, 8'hD0, 8'h00, 8'h00, 8'h00, 8'hD0, 1'b0, 2'd2, 16'h0000, 1'b0, "R5");
    put(3, 8'hF7, 8'hAB, 8'hCD, 8'h00, 8'hF7, 1'b0, 2'd3, 16'hABCD, 1'b0, "R6");
    put(2, 8'h18, 8'h08, 8'h00, 8'h00, 8'h08, 1'b1, 2'd0, 16'h0000, 1'b0, "R3");
    put(3, 8'h18, 8'h86, 8'h55, 8'h00, 8'h86, 1'b1, 2'd1, 16'h0055, 1'b0, "R3");
    put(4, 8'h18, 8'hB6, 8'h03, 8'h21, 8'hB6, 1'b1, 2'd3, 16'h0321, 1'b0, "R3");
    put(3, 8'h18, 8'h9E, 8'h44, 8'h00, 8'h9E, 1'b1, 2'd2, 16'h0044, 1'b0, "R3");
    put(1, 8'h4A, 8'h00, 8'h00, 8'h00, 8'h4A, 1'b0, 2'd0, 16'h0000, 1'b1, "R8");
    put(2, 8'h18, 8'hA5, 8'h00, 8'h00, 8'hA5, 1'b1, 2'd0, 16'h0000, 1'b1, "R8");
    put(2, 8'h18, 8'h18, 8'h00, 8'h00, 8'h18, 1'b1, 2'd0, 16'h0000, 1'b1, "R9");
    put(2, 8'h86, 8'h11, 8'h00, 8'h00, 8'h86, 1'b0, 2'd1, 16'h0011, 1'b0, "R9");
    put(1, 8'h6E, 8'h00, 8'h00, 8'h00, 8'h6E, 1'b0, 2'd0, 16'h0000, 1'b1, "R8");
    put(3, 8'hBF, 8'h00, 8'hFF, 8'h00, 8'hBF, 1'b0, 2'd3, 16'h00FF, 1'b0, "R6");
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R1", "valid after reset", 32'(out_valid), 32'd0);
    check(pc_now == RVEC, "R1", "pc after reset", 32'(pc_now), 32'(RVEC));
    check(mem_rd_en == 1'b0, "R12", "no read without start", 32'(mem_rd_en), 32'd0);
    running = 1'b1;
    wd = 0;
    while (q.size() != 0 && wd < 5000) begin
      @(posedge clk);
      wd++;
    end
    if (q.size() != 0) check(1'b0, "R11", "watchdog expired", 32'(q.size()), 32'd0);
    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule